// File: doc/BRIEF.md
# Master-Side Tagged Data Tracker

This block lives inside a bus master attached to a split-transaction memory bus. The master hands it requests through a valid/ready handshake. The block puts each request on the bus control lines. When the hub acknowledges a request, the block records the tag the hub returned, the direction of the request and its address. For writes it also records the write data and the byte mask. One table entry exists per possible tag value.

The hub completes transactions later, and in any order, by raising a call strobe together with a call tag. The tracker matches the called tag against its own table. For a write, it drives the stored data and mask onto the bus in the following cycle. For a read, it samples the hub's read data in the following cycle and hands it to the master one cycle after that, together with the original address. The write data and mask outputs are held at zero in every other cycle. This lets the outputs of several masters be merged with a plain OR. An entry is retired in its call cycle, because the hub may hand out that tag again from that cycle onward.

Top module: `split_txn_tracker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `bus_data_w`, `bus_data_wm` and `rd_valid` are zero. No tag is owned after reset.
- R2: `bus_stb`, `bus_adr` and `bus_we` follow `req_valid`, `req_addr` and `req_write`, and `req_ready` follows `bus_ack`. A request is taken only in a cycle where `req_valid` and `bus_ack` are both high. A request offered while `bus_ack` is low creates no entry.
- R3: In the cycle after a call whose tag selects an owned write, `bus_data_w` and `bus_data_wm` equal the stored data and mask. Mask bit i belongs to data bits 8i+7..8i, and a one means that byte is to be stored.
- R4: In every cycle that is not the slot after a call of an owned write, `bus_data_w` and `bus_data_wm` are all zeros.
- R5: For an owned read called in cycle C, `bus_data_r` is sampled in cycle C+1. In cycle C+2, `rd_valid` is high for one cycle, `rd_data` holds the sampled value and `rd_addr` holds the request address.
- R6: Calling a write never produces `rd_valid`. Read data present in the slot after a write call is not captured.
- R7: A call whose tag has no owned entry is ignored: the data outputs stay zero and no `rd_valid` follows.
- R8: An entry is retired in its call cycle, so a second call of the same tag without a new issue is ignored.
- R9: Calls may come in any order relative to issue, and a tag value may be reused for a new transaction after it has been called.
- R10: When a request is accepted with tag T in the same cycle that T is called, the called transaction completes with its old contents, and the new request is kept under T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master request valid |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Write data for a write request |
| req_wmask | input | DATA_W/8 | Byte mask for a write request |
| req_ready | output | 1 | Request taken this cycle when valid |
| bus_adr | output | ADDR_W | Bus request address |
| bus_we | output | 1 | Bus request direction |
| bus_stb | output | 1 | Bus request strobe |
| bus_ack | input | 1 | Hub acknowledge; issue tag valid |
| bus_tag_issue | input | TAG_W | Tag given by the hub |
| bus_call | input | 1 | Hub call strobe |
| bus_tag_call | input | TAG_W | Tag being called |
| bus_data_r | input | DATA_W | Read data from the hub, in the slot after a call |
| bus_data_w | output | DATA_W | Write data, zero outside own slot |
| bus_data_wm | output | DATA_W/8 | Write byte mask, zero outside own slot |
| rd_valid | output | 1 | Read completion pulse |
| rd_data | output | DATA_W | Completed read data |
| rd_addr | output | ADDR_W | Address of the completed read |

## Verification
The assertions assume the hub never hands out a tag that this master still owns, unless that tag is being called in the same cycle. They also assume that every write stored with a nonzero mask, so that a live write slot can be seen on `bus_data_wm`. The checker keeps its own shadow of owned tags, built only from accepted requests and calls. The directed stimulus uses distinct tags, or reuses a tag only at or after its call, and every write it issues has at least one mask bit set.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;
endpackage

// File: rtl/trk_sdp_ram.sv
// Simple dual-port RAM, read-before-write, registered read with sync clear.
module trk_sdp_ram #(
  parameter int ADDR_BITS = 2,
  parameter int WIDTH     = 32
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic                 rd_en,
  input  logic                 rd_clr,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [WIDTH-1:0]     rd_q
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_clr)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/trk_tag_table.sv
// Per-tag ownership and direction; set has priority over clear.
module trk_tag_table
  import trk_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  dir_e             set_dir,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output dir_e             look_dir
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] own_q;
  dir_e             dir_q [NTAGS];

  for (genvar i = 0; i < NTAGS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        own_q[i] <= 1'b0;
        dir_q[i] <= DIR_READ;
      end else if (set_en && set_tag == TAG_W'(i)) begin
        own_q[i] <= 1'b1;
        dir_q[i] <= set_dir;
      end else if (clr_en && look_tag == TAG_W'(i)) begin
        own_q[i] <= 1'b0;
      end
    end
  end

  assign look_hit = own_q[look_tag];
  assign look_dir = dir_q[look_tag];
endmodule

// File: rtl/trk_read_return.sv
// Samples read data in the slot after a read call, presents it one cycle later.
module trk_read_return #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] bus_data_r,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr
);
  logic slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_addr  <= '0;
    end else begin
      slot_q   <= rd_hit;
      rd_valid <= slot_q;
      if (slot_q) begin
        rd_data <= bus_data_r;
        rd_addr <= addr_q;
      end
    end
  end
endmodule

// File: rtl/split_txn_tracker.sv
module split_txn_tracker
  import trk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_wmask,
  output logic                  req_ready,
  output logic [ADDR_W-1:0]     bus_adr,
  output logic                  bus_we,
  output logic                  bus_stb,
  input  logic                  bus_ack,
  input  logic [TAG_W-1:0]      bus_tag_issue,
  input  logic                  bus_call,
  input  logic [TAG_W-1:0]      bus_tag_call,
  input  logic [DATA_W-1:0]     bus_data_r,
  output logic [DATA_W-1:0]     bus_data_w,
  output logic [DATA_W/8-1:0]   bus_data_wm,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [ADDR_W-1:0]     rd_addr
);
  localparam int MASK_W = DATA_W / 8;
  localparam int WPAY_W = DATA_W + MASK_W;

  logic accept;
  logic hit;
  dir_e hit_dir;
  logic wr_hit;
  logic rd_hit;
  logic [WPAY_W-1:0] wpay_q;
  logic [ADDR_W-1:0] addr_q;

  // Control path: strobe follows the master, ready follows the hub.
  assign bus_stb   = req_valid;
  assign bus_adr   = req_addr;
  assign bus_we    = req_write;
  assign req_ready = bus_ack;
  assign accept    = req_valid && bus_ack;

  trk_tag_table #(.TAG_W(TAG_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .set_en   (accept),
    .set_tag  (bus_tag_issue),
    .set_dir  (req_write ? DIR_WRITE : DIR_READ),
    .clr_en   (bus_call),
    .look_tag (bus_tag_call),
    .look_hit (hit),
    .look_dir (hit_dir)
  );

  assign wr_hit = bus_call && hit && (hit_dir == DIR_WRITE);
  assign rd_hit = bus_call && hit && (hit_dir == DIR_READ);

  // Write payload: the output register is the bus driver, cleared outside the slot.
  trk_sdp_ram #(.ADDR_BITS(TAG_W), .WIDTH(WPAY_W)) u_wpay (
    .clk     (clk),
    .wr_en   (accept && req_write),
    .wr_addr (bus_tag_issue),
    .wr_data ({req_wmask, req_wdata}),
    .rd_en   (wr_hit),
    .rd_clr  (rst || !wr_hit),
    .rd_addr (bus_tag_call),
    .rd_q    (wpay_q)
  );

  assign bus_data_w  = wpay_q[DATA_W-1:0];
  assign bus_data_wm = wpay_q[WPAY_W-1:DATA_W];

  // Request address, returned with read completions.
  trk_sdp_ram #(.ADDR_BITS(TAG_W), .WIDTH(ADDR_W)) u_addr (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (bus_tag_issue),
    .wr_data (req_addr),
    .rd_en   (rd_hit),
    .rd_clr  (rst),
    .rd_addr (bus_tag_call),
    .rd_q    (addr_q)
  );

  trk_read_return #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rret (
    .clk        (clk),
    .rst        (rst),
    .rd_hit     (rd_hit),
    .addr_q     (addr_q),
    .bus_data_r (bus_data_r),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr)
  );
endmodule

// File: rtl/split_txn_tracker_chk.sv
module split_txn_tracker_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                bus_ack,
  input logic [TAG_W-1:0]    bus_tag_issue,
  input logic                bus_call,
  input logic [TAG_W-1:0]    bus_tag_call,
  input logic [DATA_W-1:0]   bus_data_w,
  input logic [DATA_W/8-1:0] bus_data_wm,
  input logic                rd_valid
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] shadow_own;
  logic             call_owned;

  assign call_owned = bus_call && shadow_own[bus_tag_call];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_own <= '0;
    end else begin
      if (bus_call) shadow_own[bus_tag_call] <= 1'b0;
      if (req_valid && bus_ack) shadow_own[bus_tag_issue] <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (bus_data_w == '0 && bus_data_wm == '0 && !rd_valid));

  assert_slot_only_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_data_w != '0 || bus_data_wm != '0) |-> $past(call_owned));

  assert_rdv_timing_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_call, 2));

  assert_wslot_no_read_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_data_wm != '0) |=> !rd_valid);

  assert_unowned_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_call && !shadow_own[bus_tag_call]) |=> (bus_data_w == '0 && bus_data_wm == '0));

  assert_rdv_owned_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(call_owned, 2));
endmodule

bind split_txn_tracker split_txn_tracker_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .bus_ack       (bus_ack),
  .bus_tag_issue (bus_tag_issue),
  .bus_call      (bus_call),
  .bus_tag_call  (bus_tag_call),
  .bus_data_w    (bus_data_w),
  .bus_data_wm   (bus_data_wm),
  .rd_valid      (rd_valid)
);

// File: tb/tb_split_txn_tracker.sv
`timescale 1ns/1ps
module tb_split_txn_tracker;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int TW = 2;
  localparam int MW = DW / 8;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [MW-1:0] req_wmask;
  logic [AW-1:0] bus_adr;
  logic bus_we, bus_stb, bus_ack, bus_call;
  logic [TW-1:0] bus_tag_issue, bus_tag_call;
  logic [DW-1:0] bus_data_r, bus_data_w, rd_data;
  logic [MW-1:0] bus_data_wm;
  logic rd_valid;
  logic [AW-1:0] rd_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  split_txn_tracker #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wmask(req_wmask), .req_ready(req_ready),
    .bus_adr(bus_adr), .bus_we(bus_we), .bus_stb(bus_stb),
    .bus_ack(bus_ack), .bus_tag_issue(bus_tag_issue),
    .bus_call(bus_call), .bus_tag_call(bus_tag_call), .bus_data_r(bus_data_r),
    .bus_data_w(bus_data_w), .bus_data_wm(bus_data_wm),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Entered at a negedge; leaves request lines set without clocking.
  task automatic set_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [MW-1:0] m, input logic [TW-1:0] t);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wmask = m;
    bus_ack = 1'b1; bus_tag_issue = t;
  endtask

  task automatic clr_req();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_wmask = '0;
    bus_ack = 1'b0; bus_tag_issue = '0;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [MW-1:0] m, input logic [TW-1:0] t);
    set_req(wr, a, d, m, t);
    #1 chk("R2", "req_ready on ack", {63'd0, req_ready}, 64'd1);
    @(posedge clk); @(negedge clk);
    clr_req();
  endtask

  // Call tag t; check write slot, then read completion. Entered and left at a negedge.
  task automatic do_call(input string rq, input logic [TW-1:0] t, input logic [DW-1:0] rdat,
                         input bit exp_w, input logic [DW-1:0] exp_wd, input logic [MW-1:0] exp_wm,
                         input bit exp_r, input logic [AW-1:0] exp_ra);
    bus_call = 1'b1; bus_tag_call = t;
    @(posedge clk); @(negedge clk);
    bus_call = 1'b0; bus_tag_call = '0;
    clr_req();
    bus_data_r = rdat;
    chk(rq, "slot data_w", 64'(bus_data_w), exp_w ? 64'(exp_wd) : 64'd0);
    chk(rq, "slot data_wm", 64'(bus_data_wm), exp_w ? 64'(exp_wm) : 64'd0);
    chk(rq, "slot rd_valid low", {63'd0, rd_valid}, 64'd0);
    @(posedge clk); @(negedge clk);
    bus_data_r = 32'h5A5A_0F0F;
    chk(rq, "rd_valid", {63'd0, rd_valid}, {63'd0, exp_r});
    if (exp_r) begin
      chk(rq, "rd_data", 64'(rd_data), 64'(rdat));
      chk(rq, "rd_addr", 64'(rd_addr), 64'(exp_ra));
    end
    chk("R4", "data_w idle after slot", 64'(bus_data_w), 64'd0);
    chk("R4", "data_wm idle after slot", 64'(bus_data_wm), 64'd0);
    @(posedge clk); @(negedge clk);
    chk(rq, "rd_valid single pulse", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "data_w in reset", 64'(bus_data_w), 64'd0);
    chk("R1", "data_wm in reset", 64'(bus_data_wm), 64'd0);
    chk("R1", "rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", "data_w after reset", 64'(bus_data_w), 64'd0);
    chk("R1", "rd_valid after reset", {63'd0, rd_valid}, 64'd0);
    for (int t = 0; t < (1 << TW); t++)
      do_call("R1", TW'(t), 32'h1111_0000 + 32'(t), 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic t_handshake();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 24'hABCDEF;
    req_wdata = 32'hCAFE_F00D; req_wmask = 4'hF; bus_ack = 1'b0; bus_tag_issue = 2'd2;
    #1;
    chk("R2", "stb follows valid", {63'd0, bus_stb}, 64'd1);
    chk("R2", "adr follows req", 64'(bus_adr), 64'hABCDEF);
    chk("R2", "we follows req", {63'd0, bus_we}, 64'd1);
    chk("R2", "ready low without ack", {63'd0, req_ready}, 64'd0);
    @(posedge clk); @(negedge clk);
    clr_req();
    #1 chk("R2", "stb low when idle", {63'd0, bus_stb}, 64'd0);
    do_call("R2", 2'd2, 32'h0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic t_read();
    issue(1'b0, 24'h123456, '0, '0, 2'd1);
    do_call("R5", 2'd1, 32'hDEAD_BEEF, 1'b0, '0, '0, 1'b1, 24'h123456);
  endtask

  task automatic t_write();
    issue(1'b1, 24'h000042, 32'hA1B2_C3D4, 4'b0101, 2'd0);
    do_call("R3", 2'd0, 32'h7777_8888, 1'b1, 32'hA1B2_C3D4, 4'b0101, 1'b0, '0);
    issue(1'b1, 24'h000043, 32'h0102_0304, 4'b1000, 2'd3);
    do_call("R6", 2'd3, 32'hFFFF_FFFF, 1'b1, 32'h0102_0304, 4'b1000, 1'b0, '0);
  endtask

  task automatic t_unowned();
    issue(1'b1, 24'h000100, 32'h1234_5678, 4'hF, 2'd1);
    do_call("R7", 2'd2, 32'h9999_9999, 1'b0, '0, '0, 1'b0, '0);
    do_call("R7", 2'd1, 32'h0, 1'b1, 32'h1234_5678, 4'hF, 1'b0, '0);
  endtask

  task automatic t_retire();
    issue(1'b0, 24'h00BEEF, '0, '0, 2'd2);
    do_call("R8", 2'd2, 32'h0BAD_CAFE, 1'b0, '0, '0, 1'b1, 24'h00BEEF);
    do_call("R8", 2'd2, 32'h1357_9BDF, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic t_out_of_order();
    issue(1'b0, 24'h00A000, '0, '0, 2'd0);
    issue(1'b1, 24'h00B000, 32'hB0B0_B0B0, 4'b0011, 2'd1);
    issue(1'b0, 24'h00C000, '0, '0, 2'd2);
    do_call("R9", 2'd1, 32'h0, 1'b1, 32'hB0B0_B0B0, 4'b0011, 1'b0, '0);
    do_call("R9", 2'd2, 32'hC0C0_C0C0, 1'b0, '0, '0, 1'b1, 24'h00C000);
    issue(1'b0, 24'h00D000, '0, '0, 2'd1);
    do_call("R9", 2'd0, 32'hA0A0_A0A0, 1'b0, '0, '0, 1'b1, 24'h00A000);
    do_call("R9", 2'd1, 32'hD0D0_D0D0, 1'b0, '0, '0, 1'b1, 24'h00D000);
  endtask

  task automatic t_same_cycle();
    issue(1'b1, 24'h00E000, 32'hEEEE_1111, 4'b1100, 2'd2);
    set_req(1'b0, 24'h00F000, '0, '0, 2'd2);
    do_call("R10", 2'd2, 32'h0, 1'b1, 32'hEEEE_1111, 4'b1100, 1'b0, '0);
    do_call("R10", 2'd2, 32'hF0F0_F0F0, 1'b0, '0, '0, 1'b1, 24'h00F000);
  endtask

  initial begin
    rst = 1'b1; bus_call = 1'b0; bus_tag_call = '0; bus_data_r = '0;
    clr_req();
    @(negedge clk);
    t_reset();
    t_handshake();
    t_read();
    t_write();
    t_unowned();
    t_retire();
    t_out_of_order();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule